// File: doc/BRIEF.md
# Width-Selectable Byte FIFO with Level Comparators

This block is a first-in first-out buffer built on a fixed pool of 256 bytes. It serves either direction of a serial port: one side writes elements into it and the other side takes them out. An element can be a byte, a 16-bit halfword or a 32-bit word. The element size sets how many elements fit: 256, 128 or 64.

Software-style write strobes load three settings:
- a control word, holding the element-size code and an 8-bit fill threshold;
- a comparator word, holding three 6-bit limits;
- an operation word, which flushes the buffer, starts it or stops it.

A new element size is taken up only when a flush runs. This keeps the buffer from being reinterpreted while it holds data.

The block reports its state in two ways. A status word gives the fill level and the full and empty bits. A set of flag outputs feeds an interrupt block: full, empty, threshold reached, the three comparator results, and one-cycle strobes for overflow and underflow. The head element is always presented on the read-data port, zero-extended to 32 bits.

Top module: `widthsel_fifo`

## Requirements
- R1: After reset the buffer is empty, not started and set to byte elements, and `status` reads 32'h0000_0200.
- R2: In byte mode (size code 0), elements leave in the order they entered. `pop_data` carries bits 7:0 of the pushed word, with bits 31:8 reading zero.
- R3: In halfword mode (size code 1), 128 elements fit and full rises at the 128th push. `pop_data` carries bits 15:0 of the pushed word, with the upper bits zero.
- R4: In word mode (size code 2), 64 elements fit and full rises at the 64th push. `pop_data` carries all 32 bits. Size code 3 behaves as byte mode.
- R5: `status` holds the element count modulo 256 in bits 7:0, full in bit 8 and empty in bit 9. All other bits read zero.
- R6: An operation-word write with bit 0 set empties the buffer. Bit 1 of the same write sets the run state, and a write with bit 1 clear stops it. Stopping keeps the stored elements.
- R7: While stopped, pushes and pops change neither the contents nor the level, and they raise no strobe.
- R8: A push while running and full is dropped. `ovf` is high for exactly the cycle after that push.
- R9: A pop while running and empty is dropped. `udf` is high for exactly the cycle after that pop.
- R10: The threshold is control bits 9:2. `thd_hit` is high while the element count is at least the threshold.
- R11: The comparator word holds the stop limit in bits 5:0, the low limit in bits 15:10 and the high limit in bits 25:20. Each limit is compared with the occupied bytes divided by 4, rounded down:
  - `stop_hit` is high when that value equals the stop limit;
  - `low_hit` is high when it is at most the low limit;
  - `high_hit` is high when it is at least the high limit.
- R12: A size code written to control bits 1:0 takes effect only at the next flush.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctrl_we | input | 1 | Control word write strobe |
| ctrl_wdata | input | 32 | Control word: size code 1:0, threshold 9:2 |
| chk_we | input | 1 | Comparator word write strobe |
| chk_wdata | input | 32 | Comparator word: limits at 5:0, 15:10, 25:20 |
| op_we | input | 1 | Operation word write strobe |
| op_wdata | input | 32 | Bit 0 flush, bit 1 run |
| push | input | 1 | Push one element |
| push_data | input | 32 | Element to push (low bytes used) |
| pop | input | 1 | Pop the head element |
| pop_data | output | 32 | Head element, zero-extended; zero when empty |
| status | output | 32 | Level 7:0, full 8, empty 9 |
| full | output | 1 | Buffer holds its capacity |
| empty | output | 1 | Buffer holds nothing |
| thd_hit | output | 1 | Count at or above threshold |
| stop_hit | output | 1 | Word-level equals stop limit |
| low_hit | output | 1 | Word-level at or below low limit |
| high_hit | output | 1 | Word-level at or above high limit |
| ovf | output | 1 | Push-when-full strobe |
| udf | output | 1 | Pop-when-empty strobe |

## Verification
The assertions take for granted that an operation write wins over a push or pop in the same cycle. They also assume the element size changes only through a flush, so the count never exceeds the capacity of the current size. The bench keeps operation writes, pushes and pops in separate cycles. It changes the size code only ahead of a flush, apart from the one deliberate R12 case, where the buffer is empty.

// File: rtl/widthsel_fifo.sv
module widthsel_fifo #(
  parameter int BYTES = 256
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ctrl_we,
  input  logic [31:0] ctrl_wdata,
  input  logic        chk_we,
  input  logic [31:0] chk_wdata,
  input  logic        op_we,
  input  logic [31:0] op_wdata,
  input  logic        push,
  input  logic [31:0] push_data,
  input  logic        pop,
  output logic [31:0] pop_data,
  output logic [31:0] status,
  output logic        full,
  output logic        empty,
  output logic        thd_hit,
  output logic        stop_hit,
  output logic        low_hit,
  output logic        high_hit,
  output logic        ovf,
  output logic        udf
);
  localparam int AW = $clog2(BYTES);
  localparam int CW = AW + 1;

  logic [7:0]    mem [BYTES];
  logic [AW-1:0] wptr, rptr;
  logic [CW-1:0] cnt;
  logic [1:0]    sh;
  logic [7:0]    thd;
  logic [5:0]    lim_stop, lim_low, lim_high;
  logic          run;

  wire [CW-1:0] cap    = CW'(BYTES) >> sh;
  wire [2:0]    esz    = 3'd1 << sh;
  wire          do_push = run && push && !full && !op_we;
  wire          do_pop  = run && pop && !empty && !op_we;
  wire [CW-1:0] bytes_used = cnt << sh;
  wire [CW-1:0] words      = bytes_used >> 2;
  wire [1:0]    new_sh     = (ctrl_wdata[1:0] == 2'd3) ? 2'd0 : ctrl_wdata[1:0];
  logic [1:0]   pend_sh;

  assign full     = (cnt == cap);
  assign empty    = (cnt == '0);
  assign status   = {22'd0, empty, full, cnt[7:0]};
  assign thd_hit  = cnt >= CW'(thd);
  assign stop_hit = words == CW'(lim_stop);
  assign low_hit  = words <= CW'(lim_low);
  assign high_hit = words >= CW'(lim_high);

  always_ff @(posedge clk) begin
    for (int b = 0; b < 4; b++)
      if (do_push && (3'(b) < esz))
        mem[wptr + AW'(b)] <= push_data[8*b +: 8];
  end

  always_comb begin
    pop_data = '0;
    if (!empty)
      for (int b = 0; b < 4; b++)
        if (3'(b) < esz) pop_data[8*b +: 8] = mem[rptr + AW'(b)];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      thd <= '0;
      pend_sh <= '0;
      lim_stop <= '0;
      lim_low <= '0;
      lim_high <= '0;
    end else begin
      if (ctrl_we) begin
        pend_sh <= new_sh;
        thd <= ctrl_wdata[9:2];
      end
      if (chk_we) begin
        lim_stop <= chk_wdata[5:0];
        lim_low  <= chk_wdata[15:10];
        lim_high <= chk_wdata[25:20];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr <= '0;
      rptr <= '0;
      cnt  <= '0;
      sh   <= '0;
      run  <= 1'b0;
      ovf  <= 1'b0;
      udf  <= 1'b0;
    end else begin
      ovf <= run && push && full && !op_we;
      udf <= run && pop && empty && !op_we;
      if (op_we) begin
        run <= op_wdata[1];
        if (op_wdata[0]) begin
          wptr <= '0;
          rptr <= '0;
          cnt  <= '0;
          sh   <= pend_sh;
        end
      end else begin
        if (do_push) wptr <= wptr + AW'(esz);
        if (do_pop)  rptr <= rptr + AW'(esz);
        cnt <= cnt + CW'(do_push) - CW'(do_pop);
      end
    end
  end

  // R1 / R5: never full and empty together
  a_r5_full_empty_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(full && empty));
  // R3 / R4: count never exceeds capacity
  a_r4_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= cap);
  // R7: stopped buffer keeps its level
  a_r7_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !op_we) |=> $stable(cnt));
  // R6: flush leaves the buffer empty
  a_r6_flush_empty: assert property (@(posedge clk) disable iff (!rst_n)
    (op_we && op_wdata[0]) |=> empty);
  // R8: push into full buffer without pop leaves the level unchanged
  a_r8_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    (full && push && !pop && !op_we) |=> (cnt == $past(cnt)));
  // R9: pop from empty buffer without push keeps it empty
  a_r9_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
    (empty && pop && !push && !op_we) |=> empty);
  // R12: size changes only through a flush
  a_r12_size_on_flush: assert property (@(posedge clk) disable iff (!rst_n)
    !(op_we && op_wdata[0]) |=> $stable(sh));
endmodule

// File: tb/widthsel_fifo_bench.sv
`timescale 1ns/1ps
module widthsel_fifo_bench;
  logic clk = 0, rst_n = 0;
  logic ctrl_we = 0, chk_we = 0, op_we = 0, push = 0, pop = 0;
  logic [31:0] ctrl_wdata = 0, chk_wdata = 0, op_wdata = 0, push_data = 0;
  logic [31:0] pop_data, status;
  logic full, empty, thd_hit, stop_hit, low_hit, high_hit, ovf, udf;
  int n_run = 0, n_fail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  widthsel_fifo u_widthsel_fifo (.*);

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr_ctrl(logic [31:0] v);
    @(negedge clk); ctrl_we = 1; ctrl_wdata = v;
    @(negedge clk); ctrl_we = 0;
  endtask
  task automatic wr_chk(logic [31:0] v);
    @(negedge clk); chk_we = 1; chk_wdata = v;
    @(negedge clk); chk_we = 0;
  endtask
  task automatic wr_op(logic [31:0] v);
    @(negedge clk); op_we = 1; op_wdata = v;
    @(negedge clk); op_we = 0;
  endtask
  task automatic do_push(logic [31:0] d);
    @(negedge clk); push = 1; push_data = d;
    @(negedge clk); push = 0;
  endtask
  task automatic do_pop(output logic [31:0] d);
    @(negedge clk); d = pop_data; pop = 1;
    @(negedge clk); pop = 0;
  endtask

  task automatic t_reset();
    chk("R1 status", status, 32'h200);
    chk("R1 full", full, 0);
    chk("R1 empty", empty, 1);
  endtask

  task automatic t_idle();
    do_push(32'h11);
    chk("R7 ovf", ovf, 0);
    chk("R7 status after push", status, 32'h200);
    @(negedge clk); pop = 1; @(negedge clk); pop = 0;
    chk("R7 udf", udf, 0);
  endtask

  task automatic t_byte();
    logic [31:0] d;
    wr_op(3);
    do_push(32'hAB); do_push(32'h1CD); do_push(32'hFFFF_FFEF);
    chk("R5 level 3", status, 32'h3);
    do_pop(d); chk("R2 first", d, 32'hAB);
    do_pop(d); chk("R2 second zero-ext", d, 32'hCD);
    do_pop(d); chk("R2 third zero-ext", d, 32'hEF);
    chk("R2 empty", empty, 1);
  endtask

  task automatic t_stop();
    logic [31:0] d;
    do_push(32'h21); do_push(32'h22);
    wr_op(0);
    do_push(32'h23);
    chk("R6 stop keeps data", status, 32'h2);
    wr_op(2);
    do_pop(d); chk("R6 resumed head", d, 32'h21);
    wr_op(1);
    chk("R6 flush empties", status, 32'h200);
    do_push(32'h24);
    chk("R6 flush without run stops", status, 32'h200);
    wr_op(3);
  endtask

  task automatic t_thd();
    wr_ctrl(32'h4 << 2);
    for (int i = 0; i < 3; i++) do_push(i);
    chk("R10 below threshold", thd_hit, 0);
    do_push(3);
    chk("R10 at threshold", thd_hit, 1);
    wr_op(3);
  endtask

  task automatic t_chk();
    wr_chk(32'd1 | (32'd1 << 10) | (32'd2 << 20));
    chk("R11 low at zero", {stop_hit, low_hit, high_hit}, 3'b010);
    for (int i = 0; i < 4; i++) do_push(i);
    chk("R11 one word", {stop_hit, low_hit, high_hit}, 3'b110);
    for (int i = 0; i < 4; i++) do_push(i);
    chk("R11 two words", {stop_hit, low_hit, high_hit}, 3'b001);
    wr_op(3);
  endtask

  task automatic t_half();
    logic [31:0] d;
    wr_ctrl(32'h1);
    do_push(32'h1234);
    do_pop(d); chk("R12 size pending until flush", d, 32'h34);
    wr_op(3);
    for (int i = 0; i < 128; i++) do_push(32'hA5A5_0000 | (32'h0101 * i));
    chk("R3 full status", status, 32'h180);
    do_push(32'h9999);
    chk("R8 ovf strobe", ovf, 1);
    @(negedge clk);
    chk("R8 ovf one cycle", ovf, 0);
    chk("R8 level kept", status, 32'h180);
    for (int i = 0; i < 128; i++) begin
      do_pop(d);
      if (i == 0 || i == 127) chk("R3 order/width", d, (32'h0101 * i) & 32'hFFFF);
    end
    chk("R3 empty after drain", empty, 1);
    @(negedge clk); pop = 1; @(negedge clk); pop = 0;
    chk("R9 udf strobe", udf, 1);
    @(negedge clk);
    chk("R9 udf one cycle", udf, 0);
  endtask

  task automatic t_word();
    logic [31:0] d;
    wr_ctrl(32'h2);
    wr_op(3);
    for (int i = 0; i < 64; i++) do_push(32'h0100_0000 * i + i + 32'h00C3_0000);
    chk("R4 full at 64", status, 32'h140);
    do_pop(d); chk("R4 first word", d, 32'h00C3_0000);
    do_pop(d); chk("R4 second word", d, 32'h01C3_0001);
    wr_ctrl(32'h3);
    wr_op(3);
    do_push(32'h7766);
    do_pop(d); chk("R4 code 3 as byte", d, 32'h66);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_fail++; n_run++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_idle();
    t_byte();
    t_stop();
    t_thd();
    t_chk();
    t_half();
    t_word();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule